// File: doc/BRIEF.md
# Dual-Clock FIFO with Latent Flag Refresh

This block is a first-in first-out buffer of 512 words of 9 bits. Its write port and read port run on independent clocks, and each port has its own enable. Pointers cross between the two clock domains as Gray codes through two-stage synchronizers. As a result, the read side learns of a write only after a fixed synchronization window, and the write side learns of a read only after the same window.

Three status outputs are registered on the read clock and computed from the read side's view of the word count:
- a merged empty-or-full flag;
- a merged near-empty-or-near-full flag, driven by a static offset input P;
- a half-full flag.

Whenever a read leaves the read-side count at zero, the next read-clock edge is a latent cycle. On that edge no word is removed and the data output does not change, whatever the read enable is. Only the flags are refreshed.

Top module: `dc_fifo_latent`

## Requirements
- R1: Words leave the buffer in the order they were accepted. Each word is 9 bits and up to 512 words are held.
- R2: A write enable while the write side counts 512 held words is dropped. The pointers are not disturbed, and the words read out afterwards are exactly the first 512 accepted.
- R3: A read enable while the read side counts zero words is ignored. `rd_data` keeps its value and no word is consumed.
- R4: A write accepted at write edge k becomes visible to the read side through a two-stage Gray synchronizer. With both clocks from one source, the word can first be read at edge k+3, and an idle FIFO drops `empty_full` after edge k+3 and not earlier.
- R5: The read edge right after a read that leaves the read-side count at zero is latent. It removes no word and leaves `rd_data` unchanged even when `rd_en` is high and data has become visible. Normal popping resumes on the following edge.
- R6: `empty_full` is 1 when the read-side count after the current edge's action is 0 or 512, and 0 otherwise.
- R7: `near_edge` is 1 when that count is at most P (the value on `alm_ofs`, 0 to 255) or at least 512 − P.
- R8: `half_full` is 1 when that count is at least 257.
- R9: While `rst` is high at a clock edge, both domains clear. Afterwards `empty_full`=1, `near_edge`=1, `half_full`=0 and `rd_data`=0.
- R10: `rd_data` is registered. After an edge that accepts a read it shows the word removed, and on every other edge it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en | input | 1 | Write enable |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read enable |
| alm_ofs | input | 8 | Offset P for the near-edge flag |
| rd_data | output | 9 | Registered read word |
| empty_full | output | 1 | Empty or full |
| near_edge | output | 1 | Within P of empty or of full |
| half_full | output | 1 | Count at least 257 |

## Verification
The hardest case to reach from the ports is the latent edge that actually blocks a visible word. It only matters when a new write emerges from the synchronizer on the very edge after the FIFO drained. The stimulus therefore leaves exactly one settled word in the buffer, writes a second word two edges before the draining read, and holds `rd_en` high across the drain. This makes the blocked edge observable on `rd_data` and `empty_full`. Separate fills step the count across 16/17, 256/257 and 495/496 and then overfill past 512. After that, a seeded random mix of enables runs against a cycle model built from R4 and R5.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

    localparam int unsigned FIFO_AW     = 9;
    localparam int unsigned FIFO_DW     = 9;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic brim;   // empty or full
        logic near;   // within offset of either edge
        logic half;   // more than half occupied
    } flag_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_POP,
        RD_LATENT
    } rd_act_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic flag_t flags_for(input logic [31:0] cnt,
                                        input logic [31:0] ofs,
                                        input logic [31:0] depth);
        flag_t f;
        f.brim = (cnt == 32'd0) || (cnt == depth);
        f.near = (cnt <= ofs) || (cnt >= depth - ofs);
        f.half = (cnt >= (depth >> 1) + 32'd1);
        return f;
    endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] r;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[s-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
module fifo_mem #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end

endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side
    import fifo_pkg::*;
#(
    parameter int unsigned AW = FIFO_AW
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray
);

    localparam int unsigned   PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(2 ** AW);

    logic [PW-1:0] wbin, wbin_nxt, rbin_seen, fill;
    logic          full;

    assign rbin_seen = PW'(gray_to_bin(32'(rgray_sync)));
    assign fill      = wbin - rbin_seen;
    assign full      = (fill == DEPTH_P);
    assign mem_we    = wr_en && !full;
    assign wbin_nxt  = wbin + PW'(mem_we);
    assign waddr     = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin_to_gray(32'(wbin_nxt)));
        end
    end

    AST_WR_FILL_BOUND: assert property (@(posedge wclk) disable iff (rst)
        fill <= DEPTH_P); // R2
    AST_WR_FULL_DROP: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && full) |=> $stable(wbin)); // R2
    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R4

endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int unsigned AW = FIFO_AW
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-2:0] alm_ofs,
    output logic          mem_re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output flag_t         flags
);

    localparam int unsigned   PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(2 ** AW);

    logic [PW-1:0] rbin, rbin_nxt, wbin_seen, vis, after;
    logic          latent_q;
    rd_act_e       act;

    assign wbin_seen = PW'(gray_to_bin(32'(wgray_sync)));
    assign vis       = wbin_seen - rbin;

    always_comb begin
        if (latent_q)                   act = RD_LATENT;
        else if (rd_en && vis != '0)    act = RD_POP;
        else                            act = RD_IDLE;
    end

    assign mem_re   = (act == RD_POP);
    assign rbin_nxt = rbin + PW'(mem_re);
    assign after    = vis - PW'(mem_re);
    assign raddr    = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin     <= '0;
            rgray    <= '0;
            latent_q <= 1'b0;
            flags    <= '{brim: 1'b1, near: 1'b1, half: 1'b0};
        end else begin
            rbin     <= rbin_nxt;
            rgray    <= PW'(bin_to_gray(32'(rbin_nxt)));
            latent_q <= mem_re && (vis == PW'(1));
            flags    <= flags_for(32'(after), 32'(alm_ofs), 32'(DEPTH_P));
        end
    end

    AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk) disable iff (rst)
        (rd_en && vis == '0) |=> $stable(rbin)); // R3
    AST_LATENT_NO_MOVE: assert property (@(posedge rclk) disable iff (rst)
        latent_q |=> $stable(rbin)); // R5
    AST_LATENT_FLAGS_EMPTY: assert property (@(posedge rclk) disable iff (rst)
        latent_q |-> flags.brim); // R5
    AST_RD_VIS_BOUND: assert property (@(posedge rclk) disable iff (rst)
        vis <= DEPTH_P); // R6
    AST_WSYNC_STEP: assert property (@(posedge rclk) disable iff (rst)
        $countones(wgray_sync ^ $past(wgray_sync)) <= 1); // R4

endmodule

// File: rtl/dc_fifo_latent.sv
`timescale 1ns/1ps
module dc_fifo_latent
    import fifo_pkg::*;
#(
    parameter int unsigned AW     = FIFO_AW,
    parameter int unsigned DW     = FIFO_DW,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-2:0] alm_ofs,
    output logic [DW-1:0] rd_data,
    output logic          empty_full,
    output logic          near_edge,
    output logic          half_full
);

    localparam int unsigned PW = AW + 1;

    logic          mem_we, mem_re;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_r, rgray_w;
    flag_t         flags;

    fifo_wr_side #(.AW(AW)) u_wr (
        .wclk       (wclk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_w),
        .mem_we     (mem_we),
        .waddr      (waddr),
        .wgray      (wgray)
    );

    fifo_ptr_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_r)
    );

    fifo_ptr_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_w)
    );

    fifo_rd_side #(.AW(AW)) u_rd (
        .rclk       (rclk),
        .rst        (rst),
        .rd_en      (rd_en),
        .wgray_sync (wgray_r),
        .alm_ofs    (alm_ofs),
        .mem_re     (mem_re),
        .raddr      (raddr),
        .rgray      (rgray),
        .flags      (flags)
    );

    fifo_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rclk),
        .rst   (rst),
        .re    (mem_re),
        .raddr (raddr),
        .rdata (rd_data)
    );

    assign empty_full = flags.brim;
    assign near_edge  = flags.near;
    assign half_full  = flags.half;

    AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (rst)
        !mem_re |=> $stable(rd_data)); // R10
    AST_HALF_NOT_EMPTY: assert property (@(posedge rclk) disable iff (rst)
        (half_full && empty_full) |-> near_edge); // R8

endmodule

// File: tb/tb_dc_fifo_latent.sv
`timescale 1ns/1ps
module tb_dc_fifo_latent;

    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [8:0] wr_data;
    logic [7:0] alm_ofs;
    logic [8:0] rd_data;
    logic       empty_full, near_edge, half_full;

    always #2.5 clk = ~clk;

    dc_fifo_latent dut (
        .wclk(clk), .rclk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .alm_ofs(alm_ofs),
        .rd_data(rd_data), .empty_full(empty_full),
        .near_edge(near_edge), .half_full(half_full)
    );

    int n_cmp = 0, n_bad = 0;
    int cum, cum_d1, cum_d2, cum_d3;
    int pops, pops_d1, pops_d2, pops_d3;
    bit lat;
    int exp_rd;
    int exp_after;
    logic [8:0] q[$];

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        cum = 0; cum_d1 = 0; cum_d2 = 0; cum_d3 = 0;
        pops = 0; pops_d1 = 0; pops_d2 = 0; pops_d3 = 0;
        lat = 0; exp_rd = 0; exp_after = 0;
        q.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        model_clear();
        chk("R9 empty_full", int'(empty_full), 1);
        chk("R9 near_edge",  int'(near_edge), 1);
        chk("R9 half_full",  int'(half_full), 0);
        chk("R9 rd_data",    int'(rd_data), 0);
        rst = 1'b0;
    endtask

    // one clock edge with the given inputs, then compare against the model
    task automatic step(input bit we, input logic [8:0] wd, input bit re);
        int vis, fill_w;
        bit pop, wacc;
        vis    = cum_d3 - pops;
        pop    = re && (vis > 0) && !lat;
        fill_w = cum - pops_d3;
        wacc   = we && (fill_w < DEPTH);
        wr_en = we; wr_data = wd; rd_en = re;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        lat = pop && (vis == 1);
        if (pop) begin exp_rd = int'(q.pop_front()); pops++; end
        if (wacc) begin q.push_back(wd); cum++; end
        exp_after = vis - int'(pop);
        cum_d3 = cum_d2; cum_d2 = cum_d1; cum_d1 = cum;
        pops_d3 = pops_d2; pops_d2 = pops_d1; pops_d1 = pops;
        chk("R1/R10 rd_data", int'(rd_data), exp_rd);
        chk("R6 empty_full", int'(empty_full),
            int'(exp_after == 0 || exp_after == DEPTH));
        chk("R7 near_edge", int'(near_edge),
            int'(exp_after <= int'(alm_ofs) || exp_after >= DEPTH - int'(alm_ofs)));
        chk("R8 half_full", int'(half_full), int'(exp_after >= DEPTH/2 + 1));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 9'd0, 1'b0);
    endtask

    task automatic fill_to(input int n);
        while (cum < n) step(1'b1, 9'($urandom), 1'b0);
        idle(4);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0451));
        alm_ofs = 8'd4;
        do_reset();

        // R4: visibility window on an idle FIFO
        step(1'b1, 9'h1A5, 1'b0);
        chk("R4 edge k", int'(empty_full), 1);
        step(1'b0, 9'd0, 1'b0);
        chk("R4 edge k+1", int'(empty_full), 1);
        step(1'b0, 9'd0, 1'b0);
        chk("R4 edge k+2", int'(empty_full), 1);
        step(1'b0, 9'd0, 1'b0);
        chk("R4 edge k+3", int'(empty_full), 0);
        step(1'b0, 9'd0, 1'b1);
        chk("R4 read word", int'(rd_data), 'h1A5);
        idle(4);

        // R5: latent edge blocks a word that has just become visible
        step(1'b1, 9'h0AA, 1'b0);
        idle(4);
        step(1'b1, 9'h155, 1'b0);   // e0-2
        step(1'b0, 9'd0, 1'b0);     // e0-1
        step(1'b0, 9'd0, 1'b1);     // e0: drains
        chk("R5 drain word", int'(rd_data), 'h0AA);
        chk("R5 drain flag", int'(empty_full), 1);
        step(1'b0, 9'd0, 1'b1);     // e0+1: latent
        chk("R5 latent holds data", int'(rd_data), 'h0AA);
        chk("R5 latent refresh flag", int'(empty_full), 0);
        step(1'b0, 9'd0, 1'b1);     // e0+2
        chk("R5 resume pop", int'(rd_data), 'h155);

        // R3: reads on empty are ignored
        for (int i = 0; i < 5; i++) step(1'b0, 9'd0, 1'b1);
        chk("R3 hold on empty", int'(rd_data), 'h155);
        chk("R3 still empty", int'(empty_full), 1);

        // thresholds, then overfill (R7, R8, R2)
        alm_ofs = 8'd16;
        do_reset();
        fill_to(16);  chk("R7 count 16", int'(near_edge), 1);
        fill_to(17);  chk("R7 count 17", int'(near_edge), 0);
        fill_to(256); chk("R8 count 256", int'(half_full), 0);
        fill_to(257); chk("R8 count 257", int'(half_full), 1);
        fill_to(495); chk("R7 count 495", int'(near_edge), 0);
        fill_to(496); chk("R7 count 496", int'(near_edge), 1);
        fill_to(512);
        chk("R6 full flag", int'(empty_full), 1);
        for (int i = 0; i < 3; i++) step(1'b1, 9'($urandom), 1'b0);
        idle(4);
        chk("R2 accepted count", cum, 512);
        chk("R2 still full", int'(empty_full), 1);
        for (int i = 0; i < 512; i++) step(1'b0, 9'd0, 1'b1);
        idle(6);
        chk("R2 drained", int'(empty_full), 1);
        chk("R2 no extra words", q.size(), 0);

        // seeded random traffic with several offsets and write/read mixes
        for (int ph = 0; ph < 6; ph++) begin
            int wp, rp;
            alm_ofs = (ph % 3 == 0) ? 8'd0 : 8'($urandom_range(1, 255));
            wp = (ph % 2 == 0) ? 70 : 35;
            rp = (ph % 2 == 0) ? 35 : 70;
            for (int i = 0; i < 700; i++)
                step(($urandom % 100) < wp, 9'($urandom), ($urandom % 100) < rp);
            idle(4);
        end
        for (int i = 0; i < 800; i++) step(1'b0, 9'd0, 1'b1);
        chk("R1 all drained", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule